// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block turns a 32-bit virtual address into a physical address using two single-way, direct-mapped translation tables: one consulted for instruction fetches and one for loads and stores. Each table slot holds a match word, which carries the page tag and a valid flag, and a translate word, which carries the page frame and the permission flags. The lookup is combinational. In the same cycle as the request it returns the physical address, the rights granted and a result code. Each side has its own enable bit in a mode register. When a side is disabled, its addresses pass through unchanged with every right granted.

When a lookup that has been accepted fails, a fault classifier picks an exception code and records the failing virtual address. A missing or invalid slot becomes a table-miss exception for the requesting side. A permission failure becomes a page-fault exception for that side. Software fills the slots through a write port and acknowledges a recorded fault with a clear pulse.

The request side is a valid/ready stream. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` goes low for as long as a recorded fault is waiting, so no new request is accepted until software clears it. The response is valid in any cycle where `req_valid` is high. It does not depend on `req_ready`.

Top module: `tlbx_unit`

## Requirements
- R1: When the enable bit for the requesting side is 0 (bit 0 covers fetches, bit 1 covers loads and stores), `rsp_paddr` equals `req_vaddr`, `rsp_rights` is 3'b111 and `rsp_code` is 0 (match). Reset clears both enable bits.
- R2: The slot index is virtual address bits [18:13]. If match-word bits [31:13] differ from virtual address bits [31:13], `rsp_code` is 1 (no match).
- R3: If the tag agrees but match-word bit 0 (valid) is 0, `rsp_code` is 2 (invalid).
- R4: For a fetch (`req_kind[1]`=1), execute right comes from translate bit 4 when `supervisor`=1 and from bit 5 otherwise. It is reported in `rsp_rights` bit 2. A fetch without execute right gives `rsp_code` 3 (bad address).
- R5: For data accesses, `req_kind`=0 is a load and 1 is a store. Read right comes from translate bit 0 (supervisor) or bit 2 (user), and write right from bit 1 (supervisor) or bit 3 (user). They are reported in `rsp_rights` bits 0 and 1. A load without read right, or a store without write right, gives code 3.
- R6: On a translated match, `rsp_paddr` is translate bits [31:13] followed by virtual bits [12:0]. On any failure, `rsp_paddr` and `rsp_rights` are 0.
- R7: An accepted failure records an exception code on the next edge. Code 3 gives 3 (instruction page fault) for a fetch and 4 (data page fault) otherwise. Codes 1 and 2 give 1 (instruction table miss) for a fetch and 2 (data table miss) otherwise.
- R8: `exc_addr` holds the failing virtual address. `exc_code` and `exc_addr` keep their values until `exc_clear` sets both to 0. `req_ready` is low while `exc_code` is nonzero.
- R9: A slot write (`ent_side` 0 selects the fetch table, `ent_sel` 0 selects the match word) affects lookups from the next cycle on. A lookup in the same cycle sees the old contents.
- R10: A pulse on `xl_en_we` loads `xl_en_d` into the enable bits, which take effect from the next cycle.
- R11: After reset every match word is 0. With translation enabled, page number 0 gives code 2 and any other page number gives code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xl_en_we | input | 1 | Load the enable bits |
| xl_en_d | input | 2 | New enable bits (bit 0 fetch, bit 1 data) |
| supervisor | input | 1 | Privilege flag for permission selection |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| req_vaddr | input | 32 | Virtual address |
| rsp_code | output | 2 | 0 match, 1 no match, 2 invalid, 3 bad address |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | Granted rights: bit 0 read, 1 write, 2 execute |
| ent_we | input | 1 | Slot write strobe |
| ent_side | input | 1 | 0 fetch table, 1 data table |
| ent_idx | input | 6 | Slot index |
| ent_sel | input | 1 | 0 match word, 1 translate word |
| ent_wdata | input | 32 | Word written |
| exc_clear | input | 1 | Clears the recorded fault |
| exc_code | output | 3 | Recorded exception: 0 none, 1 I-miss, 2 D-miss, 3 I-fault, 4 D-fault |
| exc_addr | output | 32 | Recorded failing virtual address |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a slot write and a lookup of that same slot. The bench drives both together and expects the lookup to return the old contents, with the new word visible only in the following cycle. The second pair is a fault clear and a new request. While a fault is recorded, the bench asserts the clear alongside a failing request. It expects the request to be refused that cycle, the clear to empty the record, and the request to be accepted and recorded one cycle later. Randomised traffic mixes writes, mode changes, clears and requests across a few colliding pages, and a behavioural model judges every cycle.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  typedef enum logic [1:0] {
    RC_MATCH   = 2'd0,
    RC_NOMATCH = 2'd1,
    RC_INVALID = 2'd2,
    RC_BADADDR = 2'd3
  } rcode_t;

  typedef enum logic [2:0] {
    EX_NONE  = 3'd0,
    EX_IMISS = 3'd1,
    EX_DMISS = 3'd2,
    EX_IPF   = 3'd3,
    EX_DPF   = 3'd4
  } exc_t;

  // permission flag positions in the translate word
  localparam int unsigned PB_SUP_RD  = 0;
  localparam int unsigned PB_SUP_WR  = 1;
  localparam int unsigned PB_USR_RD  = 2;
  localparam int unsigned PB_USR_WR  = 3;
  localparam int unsigned PB_SUP_EX  = 4;
  localparam int unsigned PB_USR_EX  = 5;
  localparam int unsigned PERM_BITS  = 6;

  // bit positions in the rights vector
  localparam int unsigned RT_RD = 0;
  localparam int unsigned RT_WR = 1;
  localparam int unsigned RT_EX = 2;
endpackage

// File: rtl/tlbx_entry_array.sv
module tlbx_entry_array #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wsel,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] mr_o,
  output logic [WORD_W-1:0] tr_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mr_q [DEPTH];
  logic [WORD_W-1:0] tr_q [DEPTH];

  // match words reset to zero so every valid flag starts clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mr_q[i] <= '0;
    end else if (we && !wsel) begin
      mr_q[widx] <= wdata;
    end
  end

  // translate words carry no reset; they are meaningless until a valid match word exists
  always_ff @(posedge clk) begin
    if (we && wsel) tr_q[widx] <= wdata;
  end

  assign mr_o = mr_q[ridx];
  assign tr_o = tr_q[ridx];
endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
  import tlbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFS_W     = 13,
  parameter bit          CODE_SIDE = 1'b0
) (
  input  logic              enable,
  input  logic              sup,
  input  logic              is_store,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] mr,
  input  logic [ADDR_W-1:0] tr,
  output rcode_t            code,
  output logic [ADDR_W-1:0] paddr,
  output logic [2:0]        rights
);
  localparam int unsigned VPN_W = ADDR_W - OFS_W;

  logic [VPN_W-1:0] vpn;
  logic             tag_hit;
  logic             slot_valid;
  logic [2:0]       granted;
  logic             allowed;
  logic             unused_word_bits;

  assign vpn        = vaddr[ADDR_W-1:OFS_W];
  assign tag_hit    = (mr[ADDR_W-1:OFS_W] == vpn);
  assign slot_valid = mr[0];
  assign unused_word_bits = ^{mr[OFS_W-1:1], tr[OFS_W-1:PERM_BITS]};

  generate
    if (CODE_SIDE) begin : g_exec
      logic ex_ok;
      assign ex_ok   = sup ? tr[PB_SUP_EX] : tr[PB_USR_EX];
      assign granted = {ex_ok, 2'b00};
      assign allowed = ex_ok;
    end else begin : g_data
      logic rd_ok;
      logic wr_ok;
      assign rd_ok   = sup ? tr[PB_SUP_RD] : tr[PB_USR_RD];
      assign wr_ok   = sup ? tr[PB_SUP_WR] : tr[PB_USR_WR];
      assign granted = {1'b0, wr_ok, rd_ok};
      assign allowed = is_store ? wr_ok : rd_ok;
    end
  endgenerate

  always_comb begin
    code   = RC_MATCH;
    paddr  = '0;
    rights = '0;
    if (!enable) begin
      paddr  = vaddr;
      rights = 3'b111;
    end else if (!tag_hit) begin
      code = RC_NOMATCH;
    end else if (!slot_valid) begin
      code = RC_INVALID;
    end else if (!allowed) begin
      code = RC_BADADDR;
    end else begin
      paddr  = {tr[ADDR_W-1:OFS_W], vaddr[OFS_W-1:0]};
      rights = granted;
    end
  end
endmodule

// File: rtl/tlbx_fault_latch.sv
module tlbx_fault_latch
  import tlbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              fetch,
  input  rcode_t            code,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              clear,
  output logic [2:0]        exc_code,
  output logic [ADDR_W-1:0] exc_addr
);
  exc_t cls;

  always_comb begin
    unique case (code)
      RC_NOMATCH, RC_INVALID: cls = fetch ? EX_IMISS : EX_DMISS;
      default:                cls = fetch ? EX_IPF   : EX_DPF;
    endcase
  end

  // a new capture wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_code <= EX_NONE;
      exc_addr <= '0;
    end else if (accept && code != RC_MATCH) begin
      exc_code <= cls;
      exc_addr <= vaddr;
    end else if (clear) begin
      exc_code <= EX_NONE;
      exc_addr <= '0;
    end
  end
endmodule

// File: rtl/tlbx_unit.sv
module tlbx_unit
  import tlbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 13,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_en_we,
  input  logic [1:0]        xl_en_d,
  input  logic              supervisor,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [2:0]        rsp_rights,
  input  logic              ent_we,
  input  logic              ent_side,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic              ent_sel,
  input  logic [ADDR_W-1:0] ent_wdata,
  input  logic              exc_clear,
  output logic [2:0]        exc_code,
  output logic [ADDR_W-1:0] exc_addr
);
  localparam int unsigned SIDES = 2;

  logic [SIDES-1:0]  en_q;
  logic              is_fetch;
  logic [IDX_W-1:0]  look_idx;
  logic              accept;

  logic [ADDR_W-1:0] side_mr    [SIDES];
  logic [ADDR_W-1:0] side_tr    [SIDES];
  rcode_t            side_code  [SIDES];
  logic [ADDR_W-1:0] side_paddr [SIDES];
  logic [2:0]        side_rt    [SIDES];
  rcode_t            sel_code;

  assign is_fetch = req_kind[1];
  assign look_idx = req_vaddr[OFS_W +: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (xl_en_we) en_q <= xl_en_d;
  end

  // side 0 serves fetches, side 1 serves loads and stores
  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_side
      tlbx_entry_array #(
        .WORD_W (ADDR_W),
        .IDX_W  (IDX_W)
      ) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ent_we && (ent_side == s[0])),
        .wsel  (ent_sel),
        .widx  (ent_idx),
        .wdata (ent_wdata),
        .ridx  (look_idx),
        .mr_o  (side_mr[s]),
        .tr_o  (side_tr[s])
      );

      tlbx_lookup #(
        .ADDR_W    (ADDR_W),
        .OFS_W     (OFS_W),
        .CODE_SIDE (s == 0)
      ) u_look (
        .enable   (en_q[s]),
        .sup      (supervisor),
        .is_store (req_kind[0]),
        .vaddr    (req_vaddr),
        .mr       (side_mr[s]),
        .tr       (side_tr[s]),
        .code     (side_code[s]),
        .paddr    (side_paddr[s]),
        .rights   (side_rt[s])
      );
    end
  endgenerate

  assign sel_code   = is_fetch ? side_code[0]  : side_code[1];
  assign rsp_code   = sel_code;
  assign rsp_paddr  = is_fetch ? side_paddr[0] : side_paddr[1];
  assign rsp_rights = is_fetch ? side_rt[0]    : side_rt[1];

  assign req_ready = (exc_code == EX_NONE);
  assign accept    = req_valid && req_ready;

  tlbx_fault_latch #(
    .ADDR_W (ADDR_W)
  ) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .fetch    (is_fetch),
    .code     (sel_code),
    .vaddr    (req_vaddr),
    .clear    (exc_clear),
    .exc_code (exc_code),
    .exc_addr (exc_addr)
  );
endmodule

// File: rtl/tlbx_checker.sv
module tlbx_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        en_q,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [1:0]        rsp_code,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [2:0]        rsp_rights,
  input logic              exc_clear,
  input logic [2:0]        exc_code,
  input logic [ADDR_W-1:0] exc_addr
);
  logic side_off;
  logic accepted;
  assign side_off = req_kind[1] ? !en_q[0] : !en_q[1];
  assign accepted = req_valid && req_ready;

  a_r1_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && side_off) |->
      (rsp_paddr == req_vaddr && rsp_rights == 3'b111 && rsp_code == 2'd0));

  a_r4_fetch_rights_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[1] && !side_off) |-> (rsp_rights[1:0] == 2'b00));

  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_code == 2'd0) |-> (rsp_paddr[OFS_W-1:0] == req_vaddr[OFS_W-1:0]));

  a_r7_miss_class: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && (rsp_code == 2'd1 || rsp_code == 2'd2)) |=>
      (exc_code == 3'd1 || exc_code == 3'd2));

  a_r7_fault_class: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && rsp_code == 2'd3) |=> (exc_code == 3'd3 || exc_code == 3'd4));

  a_r8_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && rsp_code != 2'd0) |=> (exc_addr == $past(req_vaddr)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code != 3'd0 && !exc_clear) |=> ($stable(exc_code) && $stable(exc_addr)));

  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code != 3'd0) |-> !req_ready);
endmodule

bind tlbx_unit tlbx_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_q       (en_q),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .req_vaddr  (req_vaddr),
  .rsp_code   (rsp_code),
  .rsp_paddr  (rsp_paddr),
  .rsp_rights (rsp_rights),
  .exc_clear  (exc_clear),
  .exc_code   (exc_code),
  .exc_addr   (exc_addr)
);

// File: tb/tb_tlbx_unit.sv
module tb_tlbx_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xl_en_we;
  logic [1:0]  xl_en_d;
  logic        supervisor;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [31:0] req_vaddr;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_rights;
  logic        ent_we;
  logic        ent_side;
  logic [5:0]  ent_idx;
  logic        ent_sel;
  logic [31:0] ent_wdata;
  logic        exc_clear;
  logic [2:0]  exc_code;
  logic [31:0] exc_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [31:0] m_imr [64];
  logic [31:0] m_itr [64];
  logic [31:0] m_dmr [64];
  logic [31:0] m_dtr [64];
  logic [1:0]  m_en;
  logic [2:0]  m_exc;
  logic [31:0] m_eaddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbx_unit dut (
    .clk(clk), .rst_n(rst_n), .xl_en_we(xl_en_we), .xl_en_d(xl_en_d),
    .supervisor(supervisor), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_vaddr(req_vaddr), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .rsp_rights(rsp_rights), .ent_we(ent_we),
    .ent_side(ent_side), .ent_idx(ent_idx), .ent_sel(ent_sel),
    .ent_wdata(ent_wdata), .exc_clear(exc_clear), .exc_code(exc_code),
    .exc_addr(exc_addr)
  );

  function automatic void model_look(input logic [1:0] kind, input logic [31:0] va,
                                     input logic sup, output logic [1:0] c,
                                     output logic [31:0] pa, output logic [2:0] rt);
    logic [5:0]  idx = va[18:13];
    logic        f   = kind[1];
    logic [31:0] mr  = f ? m_imr[idx] : m_dmr[idx];
    logic [31:0] tr  = f ? m_itr[idx] : m_dtr[idx];
    logic        on  = f ? m_en[0] : m_en[1];
    logic r, w, x, ok;
    c = 2'd0; pa = 32'd0; rt = 3'd0;
    if (!on) begin
      pa = va; rt = 3'b111;
    end else if (mr[31:13] != va[31:13]) c = 2'd1;
    else if (!mr[0]) c = 2'd2;
    else begin
      x = sup ? tr[4] : tr[5];
      r = sup ? tr[0] : tr[2];
      w = sup ? tr[1] : tr[3];
      ok = f ? x : (kind[0] ? w : r);
      if (!ok) c = 2'd3;
      else begin
        pa = {tr[31:13], va[12:0]};
        rt = f ? {x, 2'b00} : {1'b0, w, r};
      end
    end
  endfunction

  function automatic string code_tag(input logic [1:0] c, input logic f);
    case (c)
      2'd0: return "R1/R6";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return f ? "R4" : "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    logic [1:0] c; logic [31:0] pa; logic [2:0] rt;
    model_look(req_kind, req_vaddr, supervisor, c, pa, rt);
    if (req_valid) begin
      chk({code_tag(c, req_kind[1]), " code"}, 32'(rsp_code), 32'(c));
      chk({code_tag(c, req_kind[1]), " R6 paddr"}, rsp_paddr, pa);
      chk({code_tag(c, req_kind[1]), " rights"}, 32'(rsp_rights), 32'(rt));
    end
    chk("R8 ready", 32'(req_ready), 32'(m_exc == 3'd0));
    chk("R7 exc_code", 32'(exc_code), 32'(m_exc));
    chk("R8 exc_addr", exc_addr, m_eaddr);
  endtask

  task automatic model_update();
    logic [1:0] c; logic [31:0] pa; logic [2:0] rt;
    logic acc;
    model_look(req_kind, req_vaddr, supervisor, c, pa, rt);
    acc = req_valid && (m_exc == 3'd0);
    if (ent_we) begin   // R9: visible from the next cycle only
      if (!ent_side) begin
        if (!ent_sel) m_imr[ent_idx] = ent_wdata; else m_itr[ent_idx] = ent_wdata;
      end else begin
        if (!ent_sel) m_dmr[ent_idx] = ent_wdata; else m_dtr[ent_idx] = ent_wdata;
      end
    end
    if (xl_en_we) m_en = xl_en_d;   // R10
    if (exc_clear) begin m_exc = 3'd0; m_eaddr = 32'd0; end
    if (acc && c != 2'd0) begin
      if (c == 2'd3) m_exc = req_kind[1] ? 3'd3 : 3'd4;
      else           m_exc = req_kind[1] ? 3'd1 : 3'd2;
      m_eaddr = req_vaddr;
    end
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    xl_en_we = 0; req_valid = 0; ent_we = 0; exc_clear = 0;
  endtask

  task automatic wr(input logic side, input logic [5:0] idx, input logic sel, input logic [31:0] d);
    idle(); ent_we = 1; ent_side = side; ent_idx = idx; ent_sel = sel; ent_wdata = d;
    tick(); idle();
  endtask

  task automatic rq(input logic [1:0] kind, input logic [31:0] va, input logic sup);
    idle(); req_valid = 1; req_kind = kind; req_vaddr = va; supervisor = sup;
    tick(); idle();
  endtask

  task automatic clr();
    idle(); exc_clear = 1; tick(); idle();
  endtask

  task automatic set_en(input logic [1:0] d);
    idle(); xl_en_we = 1; xl_en_d = d; tick(); idle();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] va;
    rst_n = 0; supervisor = 0; req_kind = 0; req_vaddr = 0; xl_en_d = 0;
    ent_side = 0; ent_idx = 0; ent_sel = 0; ent_wdata = 0;
    idle();
    for (int i = 0; i < 64; i++) begin
      m_imr[i] = 0; m_dmr[i] = 0; m_itr[i] = 0; m_dtr[i] = 0;
    end
    m_en = 0; m_exc = 0; m_eaddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R11: reset state is bypass
    rq(2'd0, 32'hDEAD_BEEF, 0);
    rq(2'd1, 32'h1234_5678, 1);
    rq(2'd2, 32'h8000_1FFC, 0);

    // preload translate words so no slot reads undefined content
    for (int i = 0; i < 64; i++) begin
      wr(1'b0, 6'(i), 1'b1, 32'd0);
      wr(1'b1, 6'(i), 1'b1, 32'd0);
    end

    // R10: enable both sides, R11: page 0 invalid, other pages no match
    set_en(2'b11);
    rq(2'd0, 32'h0000_0123, 0);   // R11 page 0 -> invalid, D-miss
    clr();
    rq(2'd2, 32'h0004_2000, 1);   // R2 no match -> I-miss
    clr();

    // R5 / R6: data slot 5, tag 0x01a05, frame 0x7abc5, all user+sup data rights differ
    va = {19'h01a05, 13'h0abc};
    wr(1'b1, 6'd5, 1'b1, {19'h7abc5, 13'b0_0000_0000_1001}); // sup read, user write
    wr(1'b1, 6'd5, 1'b0, {19'h01a05, 13'h0001});
    rq(2'd0, va, 1);   // R5 sup load ok
    rq(2'd1, va, 0);   // R5 user store ok
    rq(2'd1, va, 1);   // R5 sup store denied -> D page fault
    rq(2'd0, va, 1);   // R8 stalled while pending
    idle(); exc_clear = 1; req_valid = 1; req_kind = 2'd0; req_vaddr = va; supervisor = 0;
    tick();            // R8 clear with a refused request in the same cycle
    idle(); req_valid = 1; tick(); idle();   // R5 user load denied, captured now
    clr();

    // R4: fetch slot 9
    va = {19'h00049, 13'h1ff0};
    wr(1'b0, 6'd9, 1'b1, {19'h00111, 13'b0_0000_0010_0000}); // user exec only
    wr(1'b0, 6'd9, 1'b0, {19'h00049, 13'h0001});
    rq(2'd3, va, 0);   // R4 user fetch ok
    rq(2'd2, va, 1);   // R4 sup fetch denied -> I page fault
    clr();

    // R3: tag matches but valid clear
    wr(1'b0, 6'd9, 1'b0, {19'h00049, 13'h1ffe});
    rq(2'd2, va, 0);
    clr();

    // R9: write and lookup of the same slot in one cycle
    idle(); ent_we = 1; ent_side = 0; ent_idx = 6'd9; ent_sel = 0;
    ent_wdata = {19'h00049, 13'h0001};
    req_valid = 1; req_kind = 2'd2; req_vaddr = va; supervisor = 0;
    tick();            // old (invalid) content seen
    idle(); req_valid = 1; tick(); idle();   // new content seen
    clr();

    // R1 / R10: disable data side only
    set_en(2'b01);
    rq(2'd1, 32'hFFFF_E001, 0);
    rq(2'd2, 32'hFFFF_E001, 0);
    clr();
    set_en(2'b11);

    // randomised mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      req_valid  = ($urandom % 10) < 7;
      req_kind   = 2'($urandom);
      supervisor = 1'($urandom);
      req_vaddr  = {17'd0, 2'($urandom), 4'd0, 2'($urandom), 7'($urandom)};
      if (($urandom % 5) == 0) begin
        ent_we = 1; ent_side = 1'($urandom); ent_idx = 6'($urandom % 4);
        ent_sel = 1'($urandom);
        ent_wdata = ent_sel ? $urandom
                            : {17'd0, 2'($urandom), 4'd0, 2'($urandom), 6'($urandom), 1'($urandom)};
      end
      if (($urandom % 20) == 0) begin xl_en_we = 1; xl_en_d = 2'($urandom); end
      exc_clear = ($urandom % 3) == 0;
      tick();
    end
    idle();
    tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule